// File: doc/BRIEF.md
# MFM Track Format Byte Sequencer

This block produces, one byte at a time, everything that must be written to lay down a fresh track on a double-density floppy medium. A single start strobe launches a pass. The block then walks through gaps, sync runs, address marks, sector ID fields, data fields and placeholder CRC slots, in the order the selected track layout calls for. Three layouts are supported: IBM, ISO and perpendicular.

Each output byte comes with two flags. The first marks bytes that a downstream serial encoder must write with a missing-clock pattern. The second marks slots where a downstream unit must insert the CRC-CCITT value. That CRC unit presets its register so that the CRC covers the three A1 marks. Bytes move under a valid/ready handshake.

Several values are sampled at the moment of start and held for the whole pass:
- track, head and first sector number,
- sector count,
- size code,
- gap 3 length,
- fill byte,
- normal or deleted data mark.

Once the last sector is written, the block streams gap 4 filler until the next index strobe. It then raises done.

Top module: `mfm_track_fmt`

## Requirements
- R1: After reset, out_valid and done are low.
- R2: With layout_sel 0 (IBM), 2 (perpendicular) or 3 (treated as IBM), the stream begins with 80 bytes of 4E, 12 bytes of 00, three C2 bytes with out_mark high, one FC byte, then a gap 1 of 50 bytes of 4E.
- R3: With layout_sel 1 (ISO), the stream begins with 32 bytes of 4E and then goes straight to the first ID field; no C2 byte is ever emitted.
- R4: Each ID field is 12 bytes of 00, three A1 marks, FE, then track, head, sector number and size code in that order, then two CRC slots.
- R5: Gap 2 after each ID field is 22 bytes of 4E, or 41 bytes with the perpendicular layout.
- R6: Each data field is 12 bytes of 00, three A1 marks, a data mark (FB when deleted_mark is 0, F8 when it is 1), 128 shifted left by size_code bytes of fill_byte, then two CRC slots.
- R7: out_mark is high exactly on the A1 marks (clock pattern 0A) and the C2 marks (clock pattern 14), and on no other byte.
- R8: Each CRC slot carries byte 00 with out_crc high and out_mark low; out_crc is low on every other byte.
- R9: Gap 3 of gap3_len bytes of 4E follows each data field (none when gap3_len is 0). The sector structure repeats sector_count times. The n-th sector (n from 0) carries sector number id_first_sector+n modulo 256.
- R10: After the last sector, 4E is emitted until index_pulse is seen; the cycle after that, out_valid is low and done is high, and done stays high until the next start. index_pulse has no effect before gap 4.
- R11: While out_valid is high and out_ready is low, out_byte and its flags hold. Exactly one byte advances per cycle with both high.
- R12: start is ignored while a pass is running. All configuration inputs are captured at start, and later changes to them do not affect the pass.
- R13: With sector_count 0, gap 1 is followed directly by gap 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a format pass (honoured when idle or done) |
| index_pulse | input | 1 | Index strobe that ends gap 4 |
| layout_sel | input | 2 | 0 IBM, 1 ISO, 2 perpendicular, 3 IBM |
| sector_count | input | 8 | Sectors on the track |
| gap3_len | input | 8 | Gap 3 length in bytes |
| size_code | input | 3 | Sector size code, data field is 128 << size_code bytes |
| fill_byte | input | 8 | Data field filler |
| deleted_mark | input | 1 | Select F8 instead of FB data mark |
| id_track | input | 8 | Track byte in ID fields |
| id_head | input | 8 | Head byte in ID fields |
| id_first_sector | input | 8 | Sector number of the first sector |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | A byte is presented |
| out_byte | output | 8 | Byte value |
| out_mark | output | 1 | Write this byte with a missing-clock pattern |
| out_crc | output | 1 | CRC placeholder slot |
| done | output | 1 | Pass complete after index strobe |

## Verification
The assertions check on every cycle that:
- the mark flag appears only on A1 or C2 bytes,
- CRC slots are zero bytes without a mark,
- a stalled byte and the captured configuration stay frozen,
- done and out_valid are never high together,
- the ISO layout never produces a C2 mark.

Only the bench scenarios can show that segment lengths and ordering are right for each layout. They compare every byte of whole tracks against a stream built arithmetically in the bench. These scenarios also cover sector numbering with wrap-around, the zero-sector and zero-gap-3 cases, and termination by the index strobe.

// File: rtl/mfm_fmt_pkg.sv
package mfm_fmt_pkg;

    localparam int MAX_SIZE_CODE = 7;
    localparam int SEC_W         = 8;
    localparam int CNT_W         = $clog2((128 << MAX_SIZE_CODE) + 1);
    localparam int LEN_W         = CNT_W + 1;

    localparam logic [7:0] B_GAP  = 8'h4E;
    localparam logic [7:0] B_SYNC = 8'h00;
    localparam logic [7:0] B_A1   = 8'hA1;
    localparam logic [7:0] B_C2   = 8'hC2;
    localparam logic [7:0] B_IXAM = 8'hFC;
    localparam logic [7:0] B_IDAM = 8'hFE;
    localparam logic [7:0] B_DAM  = 8'hFB;
    localparam logic [7:0] B_DDAM = 8'hF8;

    localparam int L_GAP0      = 80;
    localparam int L_SYNC      = 12;
    localparam int L_MARK      = 3;
    localparam int L_GAP1_STD  = 50;
    localparam int L_GAP1_ISO  = 32;
    localparam int L_IDFLD     = 4;
    localparam int L_CRC       = 2;
    localparam int L_GAP2_STD  = 22;
    localparam int L_GAP2_PERP = 41;

    typedef enum logic [1:0] {
        LAY_IBM  = 2'd0,
        LAY_ISO  = 2'd1,
        LAY_PERP = 2'd2,
        LAY_ALT  = 2'd3
    } layout_e;

    typedef enum logic [4:0] {
        SEG_IDLE, SEG_GAP0, SEG_SYNC0, SEG_IXMK, SEG_IXAM, SEG_GAP1,
        SEG_IDSYNC, SEG_IDMK, SEG_IDAM, SEG_IDFLD, SEG_IDCRC, SEG_GAP2,
        SEG_DSYNC, SEG_DMK, SEG_DAM, SEG_DATA, SEG_DCRC, SEG_GAP3,
        SEG_GAP4, SEG_DONE
    } seg_e;

    typedef struct packed {
        layout_e    layout;
        logic [7:0] nsec;
        logic [7:0] gap3;
        logic [2:0] size;
        logic [7:0] fill;
        logic       deleted;
        logic [7:0] track;
        logic [7:0] head;
        logic [7:0] sbase;
    } cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       mark;
        logic       crc;
    } obyte_t;

    function automatic logic [LEN_W-1:0] seg_len(input seg_e s, input cfg_t c);
        case (s)
            SEG_GAP0:                     return LEN_W'(L_GAP0);
            SEG_SYNC0, SEG_IDSYNC,
            SEG_DSYNC:                    return LEN_W'(L_SYNC);
            SEG_IXMK, SEG_IDMK, SEG_DMK:  return LEN_W'(L_MARK);
            SEG_GAP1:  return (c.layout == LAY_ISO) ? LEN_W'(L_GAP1_ISO) : LEN_W'(L_GAP1_STD);
            SEG_IDFLD:                    return LEN_W'(L_IDFLD);
            SEG_IDCRC, SEG_DCRC:          return LEN_W'(L_CRC);
            SEG_GAP2:  return (c.layout == LAY_PERP) ? LEN_W'(L_GAP2_PERP) : LEN_W'(L_GAP2_STD);
            SEG_DATA:                     return LEN_W'(128) << c.size;
            SEG_GAP3:                     return LEN_W'(c.gap3);
            default:                      return LEN_W'(1);
        endcase
    endfunction

    function automatic logic seg_busy(input seg_e s);
        return (s != SEG_IDLE) && (s != SEG_DONE);
    endfunction

endpackage

// File: rtl/mfm_seq_fsm.sv
module mfm_seq_fsm
    import mfm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             index_pulse,
    input  logic             out_ready,
    input  cfg_t             cfg_in,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic [SEC_W-1:0] sec,
    output cfg_t             cfg
);

    logic [LEN_W-1:0] len;
    logic             last;
    logic             busy;
    logic             sec_last;
    seg_e             sec_end;
    seg_e             nxt;

    assign len      = seg_len(seg, cfg);
    assign last     = (LEN_W'(cnt) + LEN_W'(1)) == len;
    assign busy     = seg_busy(seg);
    assign sec_last = ({1'b0, sec} + (SEC_W+1)'(1)) == (SEC_W+1)'(cfg.nsec);
    assign sec_end  = sec_last ? SEG_GAP4 : SEG_IDSYNC;

    always_comb begin
        case (seg)
            SEG_GAP0:   nxt = SEG_SYNC0;
            SEG_SYNC0:  nxt = SEG_IXMK;
            SEG_IXMK:   nxt = SEG_IXAM;
            SEG_IXAM:   nxt = SEG_GAP1;
            SEG_GAP1:   nxt = (cfg.nsec == 8'd0) ? SEG_GAP4 : SEG_IDSYNC;
            SEG_IDSYNC: nxt = SEG_IDMK;
            SEG_IDMK:   nxt = SEG_IDAM;
            SEG_IDAM:   nxt = SEG_IDFLD;
            SEG_IDFLD:  nxt = SEG_IDCRC;
            SEG_IDCRC:  nxt = SEG_GAP2;
            SEG_GAP2:   nxt = SEG_DSYNC;
            SEG_DSYNC:  nxt = SEG_DMK;
            SEG_DMK:    nxt = SEG_DAM;
            SEG_DAM:    nxt = SEG_DATA;
            SEG_DATA:   nxt = SEG_DCRC;
            SEG_DCRC:   nxt = (cfg.gap3 != 8'd0) ? SEG_GAP3 : sec_end;
            SEG_GAP3:   nxt = sec_end;
            default:    nxt = seg;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg <= SEG_IDLE;
            cnt <= '0;
            sec <= '0;
            cfg <= '0;
        end else begin
            case (seg)
                SEG_IDLE, SEG_DONE: begin
                    if (start) begin
                        cfg <= cfg_in;
                        seg <= (cfg_in.layout == LAY_ISO) ? SEG_GAP1 : SEG_GAP0;
                        cnt <= '0;
                        sec <= '0;
                    end
                end
                SEG_GAP4: begin
                    if (index_pulse) seg <= SEG_DONE;
                end
                default: begin
                    if (out_ready) begin
                        if (last) begin
                            seg <= nxt;
                            cnt <= '0;
                            if (nxt == SEG_IDSYNC && (seg == SEG_DCRC || seg == SEG_GAP3))
                                sec <= sec + SEC_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !out_ready && seg != SEG_GAP4) |=> ($stable(seg) && $stable(cnt)));

    // R12
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    // R10
    index_end_chk: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_GAP4 && index_pulse) |=> (seg == SEG_DONE));

    // R13
    no_sector_chk: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_GAP1 && last && out_ready && cfg.nsec == 8'd0) |=> (seg == SEG_GAP4));

endmodule

// File: rtl/mfm_byte_gen.sv
module mfm_byte_gen
    import mfm_fmt_pkg::*;
(
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEC_W-1:0] sec,
    input  cfg_t             cfg,
    output obyte_t           ob
);

    logic [7:0] id_byte;

    always_comb begin
        case (cnt[1:0])
            2'd0:    id_byte = cfg.track;
            2'd1:    id_byte = cfg.head;
            2'd2:    id_byte = cfg.sbase + 8'(sec);
            default: id_byte = {5'd0, cfg.size};
        endcase
    end

    always_comb begin
        ob = '{data: B_GAP, mark: 1'b0, crc: 1'b0};
        case (seg)
            SEG_SYNC0, SEG_IDSYNC, SEG_DSYNC: ob.data = B_SYNC;
            SEG_IXMK:  begin ob.data = B_C2; ob.mark = 1'b1; end
            SEG_IDMK, SEG_DMK: begin ob.data = B_A1; ob.mark = 1'b1; end
            SEG_IXAM:  ob.data = B_IXAM;
            SEG_IDAM:  ob.data = B_IDAM;
            SEG_IDFLD: ob.data = id_byte;
            SEG_IDCRC, SEG_DCRC: begin ob.data = 8'h00; ob.crc = 1'b1; end
            SEG_DAM:   ob.data = cfg.deleted ? B_DDAM : B_DAM;
            SEG_DATA:  ob.data = cfg.fill;
            default:   ob.data = B_GAP;
        endcase
    end

endmodule

// File: rtl/mfm_track_fmt.sv
module mfm_track_fmt
    import mfm_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       index_pulse,
    input  logic [1:0] layout_sel,
    input  logic [7:0] sector_count,
    input  logic [7:0] gap3_len,
    input  logic [2:0] size_code,
    input  logic [7:0] fill_byte,
    input  logic       deleted_mark,
    input  logic [7:0] id_track,
    input  logic [7:0] id_head,
    input  logic [7:0] id_first_sector,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_mark,
    output logic       out_crc,
    output logic       done
);

    cfg_t             cfg_in;
    cfg_t             cfg;
    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic [SEC_W-1:0] sec;
    obyte_t           ob;

    always_comb begin
        cfg_in.layout  = layout_e'(layout_sel);
        cfg_in.nsec    = sector_count;
        cfg_in.gap3    = gap3_len;
        cfg_in.size    = size_code;
        cfg_in.fill    = fill_byte;
        cfg_in.deleted = deleted_mark;
        cfg_in.track   = id_track;
        cfg_in.head    = id_head;
        cfg_in.sbase   = id_first_sector;
    end

    mfm_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .index_pulse (index_pulse),
        .out_ready   (out_ready),
        .cfg_in      (cfg_in),
        .seg         (seg),
        .cnt         (cnt),
        .sec         (sec),
        .cfg         (cfg)
    );

    mfm_byte_gen u_gen (
        .seg (seg),
        .cnt (cnt),
        .sec (sec),
        .cfg (cfg),
        .ob  (ob)
    );

    assign out_valid = seg_busy(seg);
    assign out_byte  = ob.data;
    assign out_mark  = out_valid & ob.mark;
    assign out_crc   = out_valid & ob.crc;
    assign done      = (seg == SEG_DONE);

    // R7
    mark_byte_chk: assert property (@(posedge clk) disable iff (rst)
        out_mark |-> (out_byte == B_A1 || out_byte == B_C2));

    // R8
    crc_slot_chk: assert property (@(posedge clk) disable iff (rst)
        out_crc |-> (out_byte == 8'h00 && !out_mark));

    // R3
    iso_no_c2_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cfg.layout == LAY_ISO) |-> !(out_mark && out_byte == B_C2));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !index_pulse) |=>
            (out_valid && $stable(out_byte) && $stable(out_mark) && $stable(out_crc)));

endmodule

// File: tb/sim_mfm_track_fmt.sv
`timescale 1ns/1ps
module sim_mfm_track_fmt;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       index_pulse = 1'b0;
    logic [1:0] layout_sel = 2'd0;
    logic [7:0] sector_count = 8'd0;
    logic [7:0] gap3_len = 8'd0;
    logic [2:0] size_code = 3'd0;
    logic [7:0] fill_byte = 8'd0;
    logic       deleted_mark = 1'b0;
    logic [7:0] id_track = 8'd0;
    logic [7:0] id_head = 8'd0;
    logic [7:0] id_first_sector = 8'd0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_mark;
    logic       out_crc;
    logic       done;

    int errors = 0;
    int checks = 0;
    logic [7:0] lfsr = 8'h5B;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    mfm_track_fmt u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic add(input int n, input logic [7:0] b, input logic m, input logic c, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({b, m, c});
            tag_q.push_back(tag);
        end
    endtask

    task automatic run_pass(input logic [1:0] lay, input int nsec, input int g3, input int sz,
                            input logic [7:0] fill, input logic del, input logic [7:0] trk,
                            input logic [7:0] hd, input logic [7:0] base);
        int idx = 0;
        int cyc = 0;
        int g4 = 0;
        bit stall_prev = 0;
        logic [7:0] prev_byte = 8'h00;
        exp_q.delete();
        tag_q.delete();
        if (lay != 2'd1) begin
            add(80, 8'h4E, 0, 0, "R2"); add(12, 8'h00, 0, 0, "R2");
            add(3, 8'hC2, 1, 0, "R7");  add(1, 8'hFC, 0, 0, "R2");
            add(50, 8'h4E, 0, 0, "R2");
        end else begin
            add(32, 8'h4E, 0, 0, "R3");
        end
        for (int s = 0; s < nsec; s++) begin
            add(12, 8'h00, 0, 0, "R4"); add(3, 8'hA1, 1, 0, "R7"); add(1, 8'hFE, 0, 0, "R4");
            add(1, trk, 0, 0, "R4"); add(1, hd, 0, 0, "R4");
            add(1, 8'(base + s), 0, 0, "R9"); add(1, 8'(sz), 0, 0, "R4");
            add(2, 8'h00, 0, 1, "R8");
            add((lay == 2'd2) ? 41 : 22, 8'h4E, 0, 0, "R5");
            add(12, 8'h00, 0, 0, "R6"); add(3, 8'hA1, 1, 0, "R7");
            add(1, del ? 8'hF8 : 8'hFB, 0, 0, "R6");
            add(128 << sz, fill, 0, 0, "R6");
            add(2, 8'h00, 0, 1, "R8");
            add(g3, 8'h4E, 0, 0, "R9");
        end
        @(negedge clk);
        layout_sel = lay; sector_count = 8'(nsec); gap3_len = 8'(g3); size_code = 3'(sz);
        fill_byte = fill; deleted_mark = del; id_track = trk; id_head = hd; id_first_sector = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R12: scramble configuration after capture
        layout_sel = ~lay; sector_count = 8'(nsec + 3); gap3_len = 8'(g3 + 7); size_code = 3'(sz + 2);
        fill_byte = ~fill; deleted_mark = ~del; id_track = ~trk; id_head = ~hd; id_first_sector = ~base;
        while (g4 < 6 && cyc < 60000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[1];
            start = (cyc == 20);       // R12: ignored while busy
            index_pulse = (cyc == 40); // R10: ignored before gap 4
            if (stall_prev)
                chk(out_valid && out_byte == prev_byte, "R11 hold", int'(out_byte), int'(prev_byte));
            if (out_valid && out_ready) begin
                if (idx < exp_q.size()) begin
                    chk({out_byte, out_mark, out_crc} == exp_q[idx], tag_q[idx],
                        int'({out_byte, out_mark, out_crc}), int'(exp_q[idx]));
                    idx++;
                end else begin
                    chk({out_byte, out_mark, out_crc} == {8'h4E, 2'b00},
                        (nsec == 0) ? "R13 gap4" : "R10 gap4",
                        int'({out_byte, out_mark, out_crc}), int'({8'h4E, 2'b00}));
                    g4++;
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_byte = out_byte;
        end
        chk(idx == exp_q.size(), "R9 stream length", idx, exp_q.size());
        start = 1'b0;
        out_ready = 1'b0;
        index_pulse = 1'b1;
        @(negedge clk);
        index_pulse = 1'b0;
        chk(done && !out_valid, "R10 done after index", int'({done, out_valid}), 2);
        repeat (3) @(negedge clk);
        chk(done && !out_valid, "R10 done holds", int'({done, out_valid}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !done, "R1 reset", int'({out_valid, done}), 0);
        run_pass(2'd0, 2, 5, 0, 8'hA5, 1'b0, 8'h03, 8'h01, 8'h01);
        run_pass(2'd1, 1, 3, 1, 8'h3C, 1'b1, 8'h07, 8'h00, 8'h09);
        run_pass(2'd2, 3, 0, 0, 8'h00, 1'b0, 8'h00, 8'h01, 8'hFE);
        run_pass(2'd3, 0, 4, 2, 8'h11, 1'b0, 8'h01, 8'h00, 8'h01);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule